// File: doc/BRIEF.md
# Power-Fail Write-Protect Supervisor

This block guards a battery-backed static memory against corruption while its supply rises and falls. Two comparator flags arrive asynchronously. One says the supply sits above the write-protect threshold. The other says it sits above the battery switchover level. The block synchronizes and filters both flags and runs a small power state machine. From that state it drives four outputs: a write-protect line that gates the memory's inputs and tristates its outputs, an inhibit line that holds chip enable and write enable inactive, a battery-select line, and a freshness-seal flag.

A freshly reset supervisor starts sealed: the cell stays disconnected until the supply first qualifies above the protect threshold. After that the seal is gone until the next reset. When a valid supply returns, two delays run from one counter. Chip enable and write enable stay inhibited for a short hold, about 2 ms. Write protection stays on for a much longer recovery, about 125 ms. Both delays are given in microseconds and converted to clock cycles from a clock-frequency parameter. The threshold voltages for each supply-tolerance variant belong to the analog comparators, not to this logic.

Top module: `pwr_guard`

## Requirements
- R1: While reset is held and right after it, seal_intact_o, wr_protect_o and ctl_inhibit_o are 1 and bat_sel_o is 0.
- R2: While sealed, bat_sel_o stays 0 whatever the switchover flag does. A switchover flag that rises without the protect-threshold flag does not release the seal.
- R3: The seal is released the first time the protect-threshold flag qualifies high. seal_intact_o then stays 0 until the next reset.
- R4: A flag counts as high only after DEB_CYC consecutive synchronized high samples. A shorter high pulse has no effect, for example it leaves the seal intact.
- R5: A flag falling is acted on without filtering. Within 4 clock cycles of the protect-threshold flag falling, wr_protect_o and ctl_inhibit_o are both 1.
- R6: Once unsealed, bat_sel_o goes to 1 within 5 cycles of the switchover flag falling. It returns to 0 once that flag qualifies high again, while write protection remains on.
- R7: When the protect-threshold input rises and stays high, ctl_inhibit_o falls at the (PU_CYC+7)-th rising edge counted from the first edge after the input change.
- R8: On the same count, wr_protect_o falls at the (REC_CYC+7)-th rising edge.
- R9: If the protect-threshold flag drops during recovery, protection stays on and the recovery delay starts again from zero at the next qualified rise.
- R10: PU_CYC = CLK_HZ*PU_US/1000000 and REC_CYC = CLK_HZ*REC_US/1000000, with integer truncation. PU_CYC must be smaller than REC_CYC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; returns the block to the sealed state |
| supply_ok_a | input | 1 | Asynchronous flag: supply above the write-protect threshold |
| supply_live_a | input | 1 | Asynchronous flag: supply above the battery switchover level |
| wr_protect_o | output | 1 | 1 = memory inputs ignored and outputs tristated |
| ctl_inhibit_o | output | 1 | 1 = chip enable and write enable forced inactive |
| bat_sel_o | output | 1 | 1 = backup cell connected to the memory |
| seal_intact_o | output | 1 | 1 = freshness seal still in place, cell never enabled |

## Verification
The bench builds the block with CLK_HZ = 100000 and DEB_CYC = 4, keeping the default PU_US and REC_US. That makes the inhibit hold 200 cycles and the recovery 12500 cycles. With those values, full recoveries, a dropout in the middle of a recovery, a debounce-length glitch and a battery episode all fit in a short run. Each delay edge can then be counted exactly, and the count is set against values the bench works out itself from the microsecond settings.

// File: rtl/pwr_guard_pkg.sv
package pwr_guard_pkg;

    typedef enum logic [2:0] {
        ST_SEALED  = 3'd0,
        ST_POWERED = 3'd1,
        ST_PROTECT = 3'd2,
        ST_BATTERY = 3'd3,
        ST_RECOVER = 3'd4
    } pg_state_e;

    localparam int FLAG_N    = 2;
    localparam int FLAG_OK   = 0;
    localparam int FLAG_LIVE = 1;

    typedef struct packed {
        logic wr_protect;
        logic ctl_inhibit;
        logic bat_sel;
        logic seal_intact;
    } pg_ctrl_t;

    function automatic longint unsigned us_to_cycles(longint unsigned hz,
                                                     longint unsigned us);
        return (hz * us) / 64'd1_000_000;
    endfunction

    function automatic int cnt_width(longint unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/pg_flag_filter.sv
module pg_flag_filter #(
    parameter int DEB_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_a,
    output logic flt_q
);
    localparam int DW = (DEB_CYC < 2) ? 1 : $clog2(DEB_CYC + 1);

    logic [1:0]    meta_q;
    logic [DW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            run_q  <= '0;
            flt_q  <= 1'b0;
        end else begin
            meta_q <= {meta_q[0], raw_a};
            if (!meta_q[1]) begin
                flt_q <= 1'b0;
                run_q <= '0;
            end else if (!flt_q) begin
                if (run_q == DW'(DEB_CYC - 1)) begin
                    flt_q <= 1'b1;
                end else begin
                    run_q <= run_q + 1'b1;
                end
            end
        end
    end

    // R4
    deb_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flt_q) |-> $past(meta_q[1]));

    // R5
    fast_fall_chk: assert property (@(posedge clk) disable iff (rst)
        !meta_q[1] |=> !flt_q);

endmodule

// File: rtl/pg_power_fsm.sv
module pg_power_fsm
    import pwr_guard_pkg::*;
#(
    parameter longint unsigned PU_CYC  = 2,
    parameter longint unsigned REC_CYC = 4,
    parameter int              CW      = 3
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     ok_f,
    input  logic     live_f,
    output pg_ctrl_t ctrl
);
    pg_state_e     state_q, state_d;
    logic [CW-1:0] tmr_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SEALED:  if (ok_f) state_d = ST_RECOVER;
            ST_POWERED: begin
                if (!live_f)    state_d = ST_BATTERY;
                else if (!ok_f) state_d = ST_PROTECT;
            end
            ST_PROTECT: begin
                if (!live_f)   state_d = ST_BATTERY;
                else if (ok_f) state_d = ST_RECOVER;
            end
            ST_BATTERY: if (live_f) state_d = ST_PROTECT;
            ST_RECOVER: begin
                if (!live_f)                          state_d = ST_BATTERY;
                else if (!ok_f)                       state_d = ST_PROTECT;
                else if (tmr_q == CW'(REC_CYC - 1))   state_d = ST_POWERED;
            end
            default: state_d = ST_SEALED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_SEALED;
            tmr_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_RECOVER && state_d == ST_RECOVER) begin
                tmr_q <= tmr_q + 1'b1;
            end else begin
                tmr_q <= '0;
            end
        end
    end

    always_comb begin
        ctrl.seal_intact = (state_q == ST_SEALED);
        ctrl.bat_sel     = (state_q == ST_BATTERY);
        ctrl.wr_protect  = (state_q != ST_POWERED);
        ctrl.ctl_inhibit = (state_q != ST_POWERED) &&
                           !((state_q == ST_RECOVER) && (tmr_q >= CW'(PU_CYC)));
    end

    // R3
    seal_stays_open_chk: assert property (@(posedge clk) disable iff (rst)
        !ctrl.seal_intact |=> !ctrl.seal_intact);

    // R5
    fail_protect_chk: assert property (@(posedge clk) disable iff (rst)
        !ok_f |=> (ctrl.wr_protect && ctrl.ctl_inhibit));

    // R6
    bat_on_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.seal_intact && !live_f) |=> ctrl.bat_sel);

    // R6
    bat_off_chk: assert property (@(posedge clk) disable iff (rst)
        live_f |=> !ctrl.bat_sel);

    // R8
    release_needs_ok_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ctrl.wr_protect) |-> $past(ok_f));

    // R2
    sealed_no_bat_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl.seal_intact |-> !ctrl.bat_sel);

endmodule

// File: rtl/pwr_guard.sv
module pwr_guard
    import pwr_guard_pkg::*;
#(
    parameter longint unsigned CLK_HZ  = 200_000_000,
    parameter int              DEB_CYC = 4,
    parameter longint unsigned PU_US   = 2_000,
    parameter longint unsigned REC_US  = 125_000
) (
    input  logic clk,
    input  logic rst,
    input  logic supply_ok_a,
    input  logic supply_live_a,
    output logic wr_protect_o,
    output logic ctl_inhibit_o,
    output logic bat_sel_o,
    output logic seal_intact_o
);
    localparam longint unsigned PU_CYC  = us_to_cycles(CLK_HZ, PU_US);
    localparam longint unsigned REC_CYC = us_to_cycles(CLK_HZ, REC_US);
    localparam int              CW      = cnt_width(REC_CYC);

    logic [FLAG_N-1:0] raw_v;
    logic [FLAG_N-1:0] flt_v;
    pg_ctrl_t          ctrl;

    assign raw_v[FLAG_OK]   = supply_ok_a;
    assign raw_v[FLAG_LIVE] = supply_live_a;

    for (genvar g = 0; g < FLAG_N; g++) begin : g_flag
        pg_flag_filter #(
            .DEB_CYC (DEB_CYC)
        ) i_filter (
            .clk   (clk),
            .rst   (rst),
            .raw_a (raw_v[g]),
            .flt_q (flt_v[g])
        );
    end

    pg_power_fsm #(
        .PU_CYC  (PU_CYC),
        .REC_CYC (REC_CYC),
        .CW      (CW)
    ) i_fsm (
        .clk    (clk),
        .rst    (rst),
        .ok_f   (flt_v[FLAG_OK]),
        .live_f (flt_v[FLAG_LIVE]),
        .ctrl   (ctrl)
    );

    assign wr_protect_o  = ctrl.wr_protect;
    assign ctl_inhibit_o = ctrl.ctl_inhibit;
    assign bat_sel_o     = ctrl.bat_sel;
    assign seal_intact_o = ctrl.seal_intact;

    // R7
    inhibit_within_protect_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_inhibit_o |-> wr_protect_o);

endmodule

// File: tb/test_pwr_guard.sv
module test_pwr_guard;

    localparam longint unsigned CLK_HZ  = 100_000;
    localparam int              DEB_CYC = 4;
    localparam longint unsigned PU_US   = 2_000;
    localparam longint unsigned REC_US  = 125_000;
    localparam int EXP_PU  = int'((CLK_HZ * PU_US) / 1_000_000);
    localparam int EXP_REC = int'((CLK_HZ * REC_US) / 1_000_000);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ok_a = 1'b0;
    logic live_a = 1'b0;
    logic wr_protect, ctl_inhibit, bat_sel, seal_intact;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pwr_guard #(
        .CLK_HZ  (CLK_HZ),
        .DEB_CYC (DEB_CYC),
        .PU_US   (PU_US),
        .REC_US  (REC_US)
    ) i_pwr_guard (
        .clk           (clk),
        .rst           (rst),
        .supply_ok_a   (ok_a),
        .supply_live_a (live_a),
        .wr_protect_o  (wr_protect),
        .ctl_inhibit_o (ctl_inhibit),
        .bat_sel_o     (bat_sel),
        .seal_intact_o (seal_intact)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_near(string req, int act, int exp);
        checks++;
        if (act < exp - 1 || act > exp + 1) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cycles(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Raise the protect-threshold input and count edges until each output drops.
    task automatic rise_and_measure(output int n_inh, output int n_prot,
                                    output bit prot_gap);
        int n = 0;
        n_inh = -1;
        n_prot = -1;
        prot_gap = 1'b0;
        @(negedge clk);
        ok_a = 1'b1;
        while (n < EXP_REC + 50 && n_prot < 0) begin
            @(posedge clk);
            #1;
            n++;
            if (n_inh < 0 && !ctl_inhibit) n_inh = n;
            if (!wr_protect) n_prot = n;
            if (n_inh >= 0 && wr_protect && n_prot < 0 && ctl_inhibit) prot_gap = 1'b1;
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        cycles(4);
        chk("R1 seal during reset", seal_intact, 1);
        @(negedge clk);
        rst = 1'b0;
        cycles(3);
        chk("R1 seal_intact", seal_intact, 1);
        chk("R1 wr_protect", wr_protect, 1);
        chk("R1 ctl_inhibit", ctl_inhibit, 1);
        chk("R1 bat_sel", bat_sel, 0);
    endtask

    task automatic t_sealed();
        @(negedge clk);
        live_a = 1'b1;
        cycles(20);
        chk("R2 live alone keeps seal", seal_intact, 1);
        chk("R2 no battery while sealed", bat_sel, 0);
        @(negedge clk);
        live_a = 1'b0;
        cycles(20);
        chk("R2 low live while sealed, bat_sel", bat_sel, 0);
        @(negedge clk);
        live_a = 1'b1;
        cycles(10);
        @(negedge clk);
        ok_a = 1'b1;
        @(negedge clk);
        @(negedge clk);
        ok_a = 1'b0;
        cycles(20);
        chk("R4 short pulse leaves seal", seal_intact, 1);
        chk("R4 short pulse keeps protect", wr_protect, 1);
    endtask

    task automatic t_first_power();
        int n_inh, n_prot;
        bit gap;
        rise_and_measure(n_inh, n_prot, gap);
        chk("R3 seal released", seal_intact, 0);
        chk("R7 inhibit hold edges", n_inh, EXP_PU + 7);
        chk("R8 recovery edges", n_prot, EXP_REC + 7);
        chk("R10 hold cycles from CLK_HZ", n_inh - 7, EXP_PU);
        chk("R6 no battery when powered", bat_sel, 0);
    endtask

    task automatic t_fail_and_restart();
        int n_inh, n_prot;
        bit gap;
        bit dropped;
        @(negedge clk);
        ok_a = 1'b0;
        cycles(4);
        chk("R5 protect after fall", wr_protect, 1);
        chk("R5 inhibit after fall", ctl_inhibit, 1);
        chk("R5 no battery with live high", bat_sel, 0);
        @(negedge clk);
        ok_a = 1'b1;
        cycles(5000);
        chk("R9 still protected mid recovery", wr_protect, 1);
        @(negedge clk);
        ok_a = 1'b0;
        dropped = 1'b0;
        for (int i = 0; i < 20; i++) begin
            cycles(1);
            if (!wr_protect) dropped = 1'b1;
        end
        chk("R9 protect held through dropout", dropped, 0);
        rise_and_measure(n_inh, n_prot, gap);
        chk_near("R9 recovery restarts from zero", n_prot, EXP_REC + 7);
        chk("R9 exact restart count", n_prot, EXP_REC + 7);
        chk("R3 seal stays open", seal_intact, 0);
    endtask

    task automatic t_battery();
        int n_inh, n_prot;
        bit gap;
        @(negedge clk);
        ok_a = 1'b0;
        live_a = 1'b0;
        cycles(5);
        chk("R6 battery selected", bat_sel, 1);
        chk("R6 protected on battery", wr_protect, 1);
        chk("R3 seal stays open on battery", seal_intact, 0);
        @(negedge clk);
        live_a = 1'b1;
        cycles(8);
        chk("R6 battery released", bat_sel, 0);
        chk("R6 protect stays on", wr_protect, 1);
        rise_and_measure(n_inh, n_prot, gap);
        chk("R7 hold after battery", n_inh, EXP_PU + 7);
        chk("R8 recovery after battery", n_prot, EXP_REC + 7);
    endtask

    initial begin
        t_reset();
        t_sealed();
        t_first_power();
        t_fail_and_restart();
        t_battery();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (190_000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule